// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable behavioural model of a synchronous static RAM whose shared data bus can switch from reads to writes, and back, without idle cycles. On every rising clock edge it samples the address, three chip selects, the write strobe, one active-low write enable per 9-bit byte and a load/advance control. It then starts a new access, continues the current burst, or deselects. Write data trails its command by the same number of cycles as read data, so a write can follow a read directly on the bus.

A static mode input selects between two timings. In registered-output timing, read data passes through an output register. In flow-through timing, read data leaves the array directly and both read and write latencies are one cycle shorter. A stall input freezes the whole command pipeline. An output-enable input and a sleep input act asynchronously on the bus drivers. The bidirectional bus is split into an input, an output and a drive enable. The memory depth is a parameter; each word holds four 9-bit bytes.

Top module: `nbt_sram`

## Requirements
- R1: A new access is loaded at an edge where `stall` is low, `sel_a_n` is low, `sel_b` is high, `sel_c_n` is low and `burst` is low. `wr_n` high makes it a read and `wr_n` low makes it a write, at address `addr`.
- R2: With `flow` low, read data for a command taken at edge N is driven on `d_out` with `d_oe` high in the cycle after edge N+1.
- R3: With `flow` high, read data for a command taken at edge N is driven in the cycle after edge N itself.
- R4: Write data is taken from `d_in` at edge N+2 (`flow` low) or edge N+1 (`flow` high) for a write command taken at edge N.
- R5: `be_n[i]` low writes bits [9i+8:9i] of the word, and any subset may be low. A write with `be_n` all high leaves memory unchanged.
- R6: An edge with `stall` high changes no internal state. A read already at the output keeps driving it, a pending write keeps `d_oe` low, and the write data is taken at its edge counted in unstalled edges only.
- R7: A load edge with any chip select inactive is a deselect, and its bus cycle has `d_oe` low. Bursts continued after a deselect stay deselected, whatever the chip selects are.
- R8: With `burst` high, the previous access type continues at the next address. Its low two bits count up modulo 4 and its upper bits are kept. `wr_n` is ignored, and `be_n` is sampled again for write bursts.
- R9: `oe_n` high turns `d_oe` off at once, and `oe_n` low turns it back on at once for a pending read. `d_oe` is never high during a write data cycle.
- R10: `sleep` high turns `d_oe` off at once and freezes the block. Commands and data presented during sleep have no effect.
- R11: After reset no access is pending and `d_oe` is low.
- R12: A read of an address written by an earlier command returns the new bytes, even while that write's data is still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the command pipeline |
| flow | input | 1 | 1 = flow-through timing, 0 = registered-output timing; static |
| stall | input | 1 | High: edge is ignored, all state held |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst | input | 1 | 0 = load new access, 1 = continue burst |
| wr_n | input | 1 | Write strobe, active low (sampled on load) |
| be_n | input | NBYTE | Byte write enables, active low |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| d_in | input | 9*NBYTE | Bus input (write data) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| d_out | output | 9*NBYTE | Bus output (read data) |
| d_oe | output | 1 | Bus drive enable |

## Verification
Two cases are hard to reach from the ports. The first is a stall that lands while a late write is still waiting for its data. The stimulus puts a wrong word on `d_in` for every stalled edge and for the edge where the data would be due if stalls were counted, and the right word only on the edge counted in unstalled cycles. A read-back then shows which word was taken. The second is a read that closely follows a partial write to the same word. The stimulus issues a partial-byte write and, on the very next edge, a read of that word, so the merged result must come from the forwarding path and not from the array.

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int DEPTH = 64,
  parameter int NBYTE = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = 9,
  localparam int CW = 2,
  localparam int DW = BW * NBYTE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow,
  input  logic             stall,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             burst,
  input  logic             wr_n,
  input  logic [NBYTE-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    d_in,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [DW-1:0]    d_out,
  output logic             d_oe
);

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;

  logic [DW-1:0]    mem [DEPTH];
  op_t              op1, op2, nxt_op, dph_op;
  logic [AW-1:0]    a1, a2, nxt_a, dph_a;
  logic [NBYTE-1:0] m1, m2, dph_m;
  logic [DW-1:0]    q, fwd, rd_raw;
  logic             go, sel_all;

  assign go      = !stall && !sleep;
  assign sel_all = !sel_a_n && sel_b && !sel_c_n;
  assign rd_raw  = mem[a1];

  always_comb begin
    if (burst) begin
      nxt_op = op1;
      nxt_a  = {a1[AW-1:CW], a1[CW-1:0] + CW'(1)};
    end else begin
      nxt_op = !sel_all ? OP_NONE : (wr_n ? OP_RD : OP_WR);
      nxt_a  = addr;
    end
  end

  assign dph_op = flow ? op1 : op2;
  assign dph_a  = flow ? a1 : a2;
  assign dph_m  = flow ? m1 : m2;

  always_comb begin
    for (int b = 0; b < NBYTE; b++)
      fwd[b*BW +: BW] = (op2 == OP_WR && a2 == a1 && m2[b]) ? d_in[b*BW +: BW]
                                                            : rd_raw[b*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (go && dph_op == OP_WR)
      for (int b = 0; b < NBYTE; b++)
        if (dph_m[b]) mem[dph_a][b*BW +: BW] <= d_in[b*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1 <= OP_NONE;
      op2 <= OP_NONE;
      a1  <= '0;
      a2  <= '0;
      m1  <= '0;
      m2  <= '0;
      q   <= '0;
    end else if (go) begin
      op1 <= nxt_op;
      a1  <= nxt_a;
      m1  <= ~be_n;
      op2 <= op1;
      a2  <= a1;
      m2  <= m1;
      if (op1 == OP_RD) q <= fwd;
    end
  end

  assign d_out = flow ? rd_raw : q;
  assign d_oe  = (flow ? (op1 == OP_RD) : (op2 == OP_RD)) && !oe_n && !sleep;

  AST_LOAD_TAKES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !burst && sel_all) |=> (a1 == $past(addr)) && (op1 == ($past(wr_n) ? OP_RD : OP_WR))); // R1
  AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !flow && op1 == OP_RD) |=> op2 == OP_RD); // R2
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(op1) && $stable(op2) && $stable(a1) && $stable(a2) && $stable(q)); // R6
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !burst && !sel_all) |=> op1 == OP_NONE); // R7
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && burst) |=> (a1[CW-1:0] == $past(a1[CW-1:0]) + CW'(1)) &&
                      (a1[AW-1:CW] == $past(a1[AW-1:CW])) && (op1 == $past(op1))); // R8

endmodule

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;

  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 0;
  logic rst_n = 0;
  logic flow = 0, stall = 0, sel_a_n = 1, sel_b = 0, sel_c_n = 1, burst = 0, wr_n = 1;
  logic [3:0] be_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic oe_n = 0, sleep = 0;
  logic [DW-1:0] d_out;
  logic d_oe;

  nbt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .flow(flow), .stall(stall),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .burst(burst), .wr_n(wr_n), .be_n(be_n), .addr(addr), .d_in(d_in),
    .oe_n(oe_n), .sleep(sleep), .d_out(d_out), .d_oe(d_oe)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          due;
    logic        drive;
    logic [35:0] data;
    string       tag;
  } item_t;

  item_t       sbq[$];
  item_t       it;
  logic [35:0] model [64];
  logic [35:0] sched [4];
  int          cyc = 0;
  int          compared = 0;
  int          mism = 0;
  bit          mon_en = 0;
  int          last_kind = 0;
  logic [5:0]  last_a = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [35:0] pat(input int i);
    logic [8:0] v;
    v = i[8:0];
    return {v ^ 9'h0A5, v ^ 9'h15A, ~v, v + 9'd77};
  endfunction

  task automatic chk(input string tag, input logic exp_oe, input logic [35:0] exp_d);
    compared++;
    if (d_oe !== exp_oe || (exp_oe && d_out !== exp_d)) begin
      mism++;
      $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
               tag, d_oe, d_out, exp_oe, exp_d);
    end
  endtask

  // driver: one command per edge, expectations pushed to the scoreboard
  task automatic step(input bit sel, input bit adv, input bit we_n, input logic [3:0] ben,
                      input logic [5:0] a, input logic [35:0] wd, input string tag);
    int e, kind, lat;
    logic [5:0] ea;
    @(posedge clk); #1;
    e   = cyc + 1;
    lat = flow ? 1 : 2;
    stall = 0; sel_a_n = !sel; sel_b = sel; sel_c_n = !sel;
    burst = adv; wr_n = we_n; be_n = ben; addr = a; d_in = sched[e % 4];
    if (!adv) begin
      kind = !sel ? 0 : (we_n ? 1 : 2);
      ea   = a;
    end else begin
      kind = last_kind;
      ea   = {last_a[5:2], 2'(last_a[1:0] + 2'd1)};
    end
    last_kind = kind;
    last_a    = ea;
    if (kind == 1) begin
      sbq.push_back(item_t'{e + (flow ? 0 : 1), 1'b1, model[ea], tag});
    end else begin
      if (kind == 2) begin
        for (int b = 0; b < 4; b++)
          if (!ben[b]) model[ea][b*9 +: 9] = wd[b*9 +: 9];
        sched[(e + lat) % 4] = wd;
      end
      sbq.push_back(item_t'{e + (flow ? 0 : 1), 1'b0, '0, tag});
    end
  endtask

  task automatic idle();
    step(0, 0, 1, 4'hF, '0, '0, "R7");
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
    @(negedge clk);
    mon_en = 0;
  endtask

  // raw drive for directed scenarios (no scoreboard)
  task automatic raw(input bit st, input bit sel, input bit we_n, input logic [3:0] ben,
                     input logic [5:0] a, input logic [35:0] din);
    @(posedge clk); #1;
    stall = st; sel_a_n = !sel; sel_b = sel; sel_c_n = !sel;
    burst = 0; wr_n = we_n; be_n = ben; addr = a; d_in = din;
  endtask

  // monitor: compares bus state against the scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      while (sbq.size() > 0 && sbq[0].due < cyc) begin
        it = sbq.pop_front();
        mism++;
        $display("FAIL %s: cycle %0d not sampled, got oe=%0b, expected oe=%0b",
                 it.tag, it.due, d_oe, it.drive);
      end
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        it = sbq.pop_front();
        chk(it.tag, it.drive, it.data);
      end
    end
  end

  initial begin
    #(8 * 50000);
    mism++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) sched[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11", 1'b0, '0);

    // registered-output timing
    mon_en = 1;
    step(1, 0, 0, 4'h0, 4, pat(1), "R4");
    step(1, 0, 1, 4'hF, 4, '0,     "R1");
    step(1, 0, 0, 4'h0, 5, pat(2), "R4");
    step(1, 0, 1, 4'hF, 5, '0,     "R2");
    step(1, 0, 0, 4'h0, 6, pat(3), "R9");
    step(1, 0, 0, 4'h0, 7, pat(4), "R9");
    step(1, 0, 1, 4'hF, 6, '0,     "R2");
    step(1, 0, 1, 4'hF, 7, '0,     "R2");
    step(1, 0, 1, 4'hF, 4, '0,     "R2");
    step(1, 0, 0, 4'h0, 8, pat(5), "R5");
    step(1, 0, 0, 4'b1010, 8, pat(6), "R5");
    step(1, 0, 1, 4'hF, 8, '0,     "R12");
    step(1, 0, 0, 4'hF, 8, pat(7), "R5");
    step(1, 0, 1, 4'hF, 8, '0,     "R5");
    step(1, 0, 0, 4'h0, 12, pat(8), "R8");
    step(1, 1, 1, 4'b0011, 0, pat(9), "R8");
    step(1, 1, 0, 4'h0, 0, pat(10), "R8");
    step(1, 1, 1, 4'h0, 0, pat(11), "R8");
    step(1, 0, 1, 4'hF, 14, '0, "R8");
    step(1, 1, 0, 4'h0, 0, '0, "R8");
    step(1, 1, 0, 4'h0, 0, '0, "R8");
    step(1, 1, 0, 4'h0, 0, '0, "R8");
    step(0, 0, 1, 4'hF, 4, '0, "R7");
    step(1, 1, 1, 4'hF, 0, '0, "R7");
    step(1, 1, 0, 4'h0, 0, '0, "R7");
    step(1, 0, 1, 4'hF, 5, '0, "R1");
    idle(); idle();
    drain();

    // R6: stall holds a read on the bus
    raw(0, 1, 1, 4'hF, 4, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    raw(1, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R6", 1'b1, model[4]);
    raw(1, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R6", 1'b1, model[4]);
    raw(0, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R6", 1'b1, model[4]);
    raw(0, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R6", 1'b0, '0);

    // R6: stall shifts the late-write data edge
    raw(0, 1, 0, 4'h0, 9, pat(40));
    raw(1, 0, 1, 4'hF, 0, pat(41));
    raw(1, 0, 1, 4'hF, 0, pat(42));
    raw(0, 0, 1, 4'hF, 0, pat(43));
    raw(0, 0, 1, 4'hF, 0, pat(44));
    @(negedge clk) chk("R6", 1'b0, '0);
    model[9] = pat(44);
    raw(0, 1, 1, 4'hF, 9, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R6", 1'b1, model[9]);

    // R9: asynchronous output enable
    oe_n = 1;
    raw(0, 1, 1, 4'hF, 4, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R9", 1'b0, '0);
    oe_n = 0;
    #1 chk("R9", 1'b1, model[4]);

    // R10: sleep blanks the bus and blocks commands
    raw(0, 1, 1, 4'hF, 4, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R10", 1'b1, model[4]);
    sleep = 1;
    #1 chk("R10", 1'b0, '0);
    raw(0, 1, 0, 4'h0, 4, pat(50));
    raw(0, 0, 1, 4'hF, 0, pat(50));
    raw(0, 0, 1, 4'hF, 0, pat(50));
    raw(0, 0, 1, 4'hF, 0, pat(50));
    @(negedge clk) sleep = 0;
    raw(0, 1, 1, 4'hF, 4, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    raw(0, 0, 1, 4'hF, 0, '0);
    @(negedge clk) chk("R10", 1'b1, model[4]);
    raw(0, 0, 1, 4'hF, 0, '0);
    raw(0, 0, 1, 4'hF, 0, '0);

    // flow-through timing
    @(negedge clk) flow = 1;
    last_kind = 0;
    mon_en = 1;
    step(1, 0, 0, 4'h0, 20, pat(20), "R4");
    step(1, 0, 1, 4'hF, 20, '0, "R3");
    step(1, 0, 0, 4'h0, 21, pat(21), "R4");
    step(1, 0, 0, 4'b1001, 21, pat(22), "R12");
    step(1, 0, 1, 4'hF, 21, '0, "R12");
    step(1, 0, 1, 4'hF, 20, '0, "R3");
    step(1, 0, 1, 4'hF, 12, '0, "R8");
    step(1, 1, 1, 4'hF, 0, '0, "R8");
    step(1, 1, 0, 4'h0, 0, '0, "R8");
    step(1, 1, 1, 4'hF, 0, '0, "R8");
    step(1, 0, 0, 4'hF, 8, pat(23), "R5");
    step(1, 0, 1, 4'hF, 8, '0, "R5");
    step(0, 0, 1, 4'hF, 8, '0, "R7");
    idle(); idle();
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

endmodule